// File: doc/BRIEF.md
# Single-Error-Correcting Banked Memory Wrapper

This block is a synchronous single-port memory that guards each 32-bit data word with six Hamming check bits. On a write, the check bits are computed from the incoming data and the 38-bit coded word is stored. On a read, the stored word is checked again. A syndrome decoder finds any single flipped bit and flips it back before the data leaves the block. Two status flags tell the requester whether a repair took place or whether the error could not be located.

The storage is divided into a power-of-two number of banks. Each bank is written as an inferred array with a registered read port, so it maps onto block RAM. The upper address bits select the bank and the lower bits select the word inside it. A registered bank selector steers the read multiplexer.

A sleep input keeps every stored word but turns away accesses. Any request made while sleep is high has no effect on the memory. The block answers it with a one-cycle refusal pulse.

Top module: `ecc_bank_mem`

## Requirements
- R1: While reset is high at a clock edge, rd_valid, corr_err, uncorr_err and sleep_deny read 0 after that edge, and rd_data reads 0.
- R2: A read (req=1, wr_en=0, sleep=0) returns the last data written to that address on rd_data, with rd_valid=1, in the cycle after the request edge. rd_valid is 0 after any other cycle, including writes and idle cycles.
- R3: The codeword layout is as follows. Codeword position p (1..38) is stored at bit p-1. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bits 0..31 fill the remaining positions in ascending order. The check bit at position 2^k makes the XOR of all bits whose position has bit k set equal to zero. A word built this way reads back clean.
- R4: If exactly one of the 38 stored bits is flipped, including a check bit, the read returns the original data with corr_err=1 and uncorr_err=0.
- R5: A clean stored word reads back with corr_err=0 and uncorr_err=0.
- R6: If the syndrome is nonzero and greater than 38, the read sets uncorr_err=1 and corr_err=0. rd_data then carries the stored data bits unchanged. The two flags are never high together.
- R7: If the syndrome of a multi-bit error falls in 1..38, the error is treated as a single error at that position. That bit is inverted and corr_err is set.
- R8: The upper address bits select the bank. A write changes only the addressed word, so the same word offset in other banks keeps its contents.
- R9: A request made while sleep=1 performs no read or write. sleep_deny is 1 in the following cycle, and stored contents survive the sleep period.
- R10: In any cycle where rd_valid=0, both error flags are 0 and rd_data keeps the value of the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request |
| wr_en | input | 1 | 1 = write, 0 = read, qualified by req |
| addr | input | ADDR_W | Word address; upper bits select the bank |
| wr_data | input | 32 | Data to store |
| sleep | input | 1 | Retention mode; accesses are refused |
| rd_data | output | 32 | Corrected read data |
| rd_valid | output | 1 | rd_data and flags belong to a read from the previous cycle |
| corr_err | output | 1 | A single-bit repair was applied |
| uncorr_err | output | 1 | Syndrome points outside the codeword |
| sleep_deny | output | 1 | Pulse for a request refused during sleep |

## Verification
The bench builds the block with four banks of four words each, giving a 4-bit address. This keeps the whole address space small enough to fill and read back completely, and it puts every bank boundary within a handful of accesses. With this small array, the bench can place a codeword it built itself into any bank directly. That lets it reach single flips at check and data positions, double flips whose syndrome lands past position 38, and double flips that alias onto a valid position. None of these could be produced through the write port.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;

  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int CODE_W = DATA_W + CHK_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CHK_W-1:0]  syn_t;

  // Positions that are powers of two carry check bits.
  function automatic bit is_chk_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Scatter data bits over the non-check positions, ascending.
  function automatic code_t place_data(data_t d);
    code_t cw;
    int    di;
    cw = '0;
    di = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_chk_pos(p)) begin
        cw[p-1] = d[di];
        di++;
      end
    end
    return cw;
  endfunction

  // Collect data bits back from the non-check positions.
  function automatic data_t gather_data(code_t cw);
    data_t d;
    int    di;
    d  = '0;
    di = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_chk_pos(p)) begin
        d[di] = cw[p-1];
        di++;
      end
    end
    return d;
  endfunction

  // Positions covered by check bit k; optionally including the check position itself.
  function automatic code_t cover_mask(int k, bit with_chk);
    code_t m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (((p >> k) & 1) == 1) begin
        if (with_chk || (p != (1 << k))) m[p-1] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_mem_pkg::*;
(
  input  data_t data_i,
  output code_t code_o
);

  code_t base;
  syn_t  chk;

  assign base = place_data(data_i);

  // One XOR tree per check bit.
  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam code_t MASK = cover_mask(k, 1'b0);
    assign chk[k] = ^(base & MASK);
  end

  always_comb begin
    code_o = base;
    for (int k = 0; k < CHK_W; k++) begin
      code_o[(1 << k) - 1] = chk[k];
    end
  end

endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
  import ecc_mem_pkg::*;
(
  input  code_t code_i,
  output data_t data_o,
  output logic  fixed_o,
  output logic  fail_o
);

  syn_t  syn;
  code_t hot;
  code_t repaired;

  // Recheck parity: one XOR tree per syndrome bit.
  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    localparam code_t MASK = cover_mask(k, 1'b1);
    assign syn[k] = ^(code_i & MASK);
  end

  // Decoder to a one-hot error position, then one inverter/2:1 mux per bit.
  for (genvar p = 0; p < CODE_W; p++) begin : g_fix
    assign hot[p]      = (syn == CHK_W'(p + 1));
    assign repaired[p] = hot[p] ? ~code_i[p] : code_i[p];
  end

  assign data_o  = gather_data(repaired);
  assign fixed_o = |hot;
  assign fail_o  = (syn != '0) && !(|hot);

endmodule

// File: rtl/mem_bank.sv
module mem_bank #(
  parameter int WORD_W = 38,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Registered read port; holds its value between reads.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/ecc_bank_mem.sv
module ecc_bank_mem
  import ecc_mem_pkg::*;
#(
  parameter int  NUM_BANKS  = 16,
  parameter int  BANK_DEPTH = 64,
  localparam int BANK_AW    = $clog2(NUM_BANKS),
  localparam int WORD_AW    = $clog2(BANK_DEPTH),
  localparam int ADDR_W     = BANK_AW + WORD_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  input  logic              sleep,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              corr_err,
  output logic              uncorr_err,
  output logic              sleep_deny
);

  logic               do_wr;
  logic               do_rd;
  logic [BANK_AW-1:0] bank_idx;
  logic [WORD_AW-1:0] word_idx;
  logic [BANK_AW-1:0] sel_q;
  logic               valid_q;
  logic               deny_q;
  code_t              enc_word;
  code_t              bank_q [NUM_BANKS];
  code_t              sel_word;
  logic               fix_raw;
  logic               fail_raw;

  assign do_wr    = req && !sleep && wr_en;
  assign do_rd    = req && !sleep && !wr_en;
  assign bank_idx = addr[ADDR_W-1 -: BANK_AW];
  assign word_idx = addr[WORD_AW-1:0];

  ecc_encoder u_enc (
    .data_i (wr_data),
    .code_o (enc_word)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_idx == BANK_AW'(b));
    mem_bank #(
      .WORD_W (CODE_W),
      .DEPTH  (BANK_DEPTH)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (do_wr && hit),
      .re    (do_rd && hit),
      .addr  (word_idx),
      .wdata (enc_word),
      .rdata (bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      valid_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      valid_q <= do_rd;
      deny_q  <= req && sleep;
      if (do_rd) sel_q <= bank_idx;
    end
  end

  assign sel_word = bank_q[sel_q];

  ecc_corrector u_fix (
    .code_i  (sel_word),
    .data_o  (rd_data),
    .fixed_o (fix_raw),
    .fail_o  (fail_raw)
  );

  assign rd_valid   = valid_q;
  assign corr_err   = valid_q && fix_raw;
  assign uncorr_err = valid_q && fail_raw;
  assign sleep_deny = deny_q;

endmodule

// File: rtl/ecc_bank_mem_chk.sv
module ecc_bank_mem_chk (
  input logic        clk,
  input logic        rst,
  input logic        req,
  input logic        wr_en,
  input logic        sleep,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        corr_err,
  input logic        uncorr_err,
  input logic        sleep_deny
);

  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    (req && !wr_en && !sleep) |=> rd_valid);

  a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    !(req && !wr_en && !sleep) |=> !rd_valid);

  a_r9_deny_pulse: assert property (@(posedge clk) disable iff (rst)
    (req && sleep) |=> sleep_deny);

  a_r9_no_stray_deny: assert property (@(posedge clk) disable iff (rst)
    !(req && sleep) |=> !sleep_deny);

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(corr_err && uncorr_err));

  a_r10_flags_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (!corr_err && !uncorr_err));

  a_r10_data_held: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data));

endmodule

bind ecc_bank_mem ecc_bank_mem_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .wr_en      (wr_en),
  .sleep      (sleep),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .corr_err   (corr_err),
  .uncorr_err (uncorr_err),
  .sleep_deny (sleep_deny)
);

// File: tb/sim_ecc_bank_mem.sv
`timescale 1ns/1ps
module sim_ecc_bank_mem;

  localparam int NB = 4;
  localparam int BD = 4;
  localparam int AW = 4;
  localparam int NW = NB * BD;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wr_data = '0;
  logic          sleep = 1'b0;
  logic [31:0]   rd_data;
  logic          rd_valid;
  logic          corr_err;
  logic          uncorr_err;
  logic          sleep_deny;

  always #2 clk = ~clk;

  ecc_bank_mem #(.NUM_BANKS(NB), .BANK_DEPTH(BD)) u0 (
    .clk(clk), .rst(rst), .req(req), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .sleep(sleep), .rd_data(rd_data), .rd_valid(rd_valid),
    .corr_err(corr_err), .uncorr_err(uncorr_err), .sleep_deny(sleep_deny)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;
  string cur_tag = "R2";

  // Reference model state: stored codewords per address.
  logic [37:0] mdl [NW];
  bit          e_rst   = 1;
  bit          e_valid = 0;
  bit          e_deny  = 0;
  bit          e_corr  = 0;
  bit          e_unc   = 0;
  logic [31:0] e_data  = '0;
  string       e_tag   = "R1";

  // Build a codeword: check bits come from the XOR of the positions of set data bits.
  function automatic logic [37:0] b_enc(logic [31:0] d);
    logic [37:0] cw = '0;
    int di = 0;
    int s  = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p-1] = d[di];
        if (d[di]) s ^= p;
        di++;
      end
    end
    for (int k = 0; k < 6; k++) cw[(1 << k) - 1] = s[k];
    return cw;
  endfunction

  function automatic void b_dec(logic [37:0] cw, output logic [31:0] d,
                                output bit c, output bit u);
    int s  = 0;
    int di = 0;
    for (int p = 1; p <= 38; p++) if (cw[p-1]) s ^= p;
    c = 0;
    u = 0;
    if (s != 0 && s <= 38) begin
      cw[s-1] = ~cw[s-1];
      c = 1;
    end else if (s != 0) begin
      u = 1;
    end
    d = '0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[di] = cw[p-1];
        di++;
      end
    end
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Model update at the clock edge (inputs are stable since the previous negedge).
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      e_rst = 1; e_valid = 0; e_deny = 0; e_corr = 0; e_unc = 0; e_data = '0;
    end else begin
      e_rst   = 0;
      e_valid = req && !wr_en && !sleep;
      e_deny  = req && sleep;
      if (e_valid) begin
        b_dec(mdl[addr], e_data, e_corr, e_unc);
        e_tag = cur_tag;
      end else begin
        e_corr = 0;
        e_unc  = 0;
      end
      if (req && wr_en && !sleep) mdl[addr] = b_enc(wr_data);
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      if (e_rst) begin
        chk(rd_valid === 1'b0, "R1 rd_valid", 64'(rd_valid), 0);
        chk(sleep_deny === 1'b0, "R1 sleep_deny", 64'(sleep_deny), 0);
        chk({corr_err, uncorr_err} === 2'b00, "R1 flags", 64'({corr_err, uncorr_err}), 0);
        chk(rd_data === 32'h0, "R1 rd_data", 64'(rd_data), 0);
      end else begin
        chk(rd_valid === e_valid, "R2 rd_valid", 64'(rd_valid), 64'(e_valid));
        chk(sleep_deny === e_deny, "R9 sleep_deny", 64'(sleep_deny), 64'(e_deny));
        if (e_valid) begin
          chk(rd_data === e_data, {e_tag, " rd_data"}, 64'(rd_data), 64'(e_data));
          chk(corr_err === e_corr, {e_tag, " corr_err"}, 64'(corr_err), 64'(e_corr));
          chk(uncorr_err === e_unc, {e_tag, " uncorr_err"}, 64'(uncorr_err), 64'(e_unc));
        end else begin
          chk({corr_err, uncorr_err} === 2'b00, "R10 flags quiet",
              64'({corr_err, uncorr_err}), 0);
          chk(rd_data === e_data, "R10 rd_data held", 64'(rd_data), 64'(e_data));
        end
      end
    end
  end

  task automatic drive(bit r, bit w, int a, logic [31:0] d, string tag);
    @(negedge clk);
    req = r; wr_en = w; addr = AW'(a); wr_data = d; cur_tag = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, '0, "R10");
  endtask

  // Place a codeword straight into a bank to model a stored fault.
  task automatic poke(int a, logic [37:0] cw);
    int w = a % BD;
    @(negedge clk);
    req = 0;
    case (a / BD)
      0: u0.g_bank[0].u_bank.mem[w] = cw;
      1: u0.g_bank[1].u_bank.mem[w] = cw;
      2: u0.g_bank[2].u_bank.mem[w] = cw;
      default: u0.g_bank[3].u_bank.mem[w] = cw;
    endcase
    mdl[a] = cw;
  endtask

  function automatic logic [37:0] flip(logic [37:0] cw, int p);
    return cw ^ (38'd1 << (p - 1));
  endfunction

  initial begin
    int one_pos [8] = '{1, 2, 3, 16, 32, 33, 38, 20};
    repeat (3) @(negedge clk);
    rst = 0;
    // R2/R8: fill every address, then read back every address (R5 clean).
    for (int a = 0; a < NW; a++) drive(1, 1, a, 32'hA500_0000 ^ (32'h0101_0101 * a), "R8");
    for (int a = 0; a < NW; a++) drive(1, 0, a, '0, "R5");
    idle(3);
    // R8: overwrite one bank's word 1 and recheck the same offset elsewhere.
    drive(1, 1, 5, 32'h0BAD_F00D, "R8");
    for (int b = 0; b < NB; b++) drive(1, 0, b * BD + 1, '0, "R8");
    // R3: a bench-built codeword reads back clean.
    poke(6, b_enc(32'hDEAD_BEEF));
    drive(1, 0, 6, '0, "R3");
    // R4: single flips at check and data positions.
    for (int i = 0; i < 8; i++) begin
      poke(i * 2, flip(b_enc(32'h1234_5678 + i), one_pos[i]));
      drive(1, 0, i * 2, '0, "R4");
    end
    // R6: double flips whose syndrome exceeds 38.
    poke(3, flip(flip(b_enc(32'hCAFE_0001), 32), 31));
    drive(1, 0, 3, '0, "R6");
    poke(7, flip(flip(b_enc(32'hCAFE_0002), 36), 3));
    drive(1, 0, 7, '0, "R6");
    poke(11, flip(flip(b_enc(32'hCAFE_0003), 37), 2));
    drive(1, 0, 11, '0, "R6");
    // R7: double flips aliasing onto a valid position.
    poke(13, flip(flip(b_enc(32'hCAFE_0004), 1), 2));
    drive(1, 0, 13, '0, "R7");
    poke(15, flip(flip(b_enc(32'hCAFE_0005), 33), 38));
    drive(1, 0, 15, '0, "R7");
    idle(2);
    // R9: requests during sleep are refused; contents kept.
    @(negedge clk);
    sleep = 1;
    drive(1, 1, 9, 32'hFFFF_FFFF, "R9");
    drive(1, 0, 9, '0, "R9");
    drive(0, 0, 0, '0, "R9");
    @(negedge clk);
    sleep = 0;
    drive(1, 0, 9, '0, "R9");
    drive(1, 0, 5, '0, "R9");
    idle(3);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule